// File: doc/BRIEF.md
# Multiply-Accumulate Product and Accumulator Conditioning Unit

This block is the conditioning datapath of a multiply-accumulate engine. It has four accumulators. Each holds a 48-bit value plus 16 guard bits, so every register is 64 bits wide. A 32x32 product is conditioned according to the active arithmetic mode: signed integer, unsigned integer, or fractional. The product is then added to an accumulator, and the sum is checked for overflow and clamped or truncated. A separate readout path turns any accumulator into a 32-bit word. In fractional mode that word is rounded and may be narrowed to 16 bits. In all modes it is saturated as required.

All state changes on a rising clock edge while the single-cycle `cmd_valid` strobe is high. The command is chosen by `cmd_op`:

| Code | Command |
|---|---|
| 0 | idle |
| 1 | load an accumulator from `wr_data` |
| 2 | multiply-accumulate |
| 3 | accumulator check only |
| 4 | copy accumulator `cmd_src` to `cmd_acc` |
| 5 | write the status word from `wr_data[15:0]` |

The status word holds the following bits:

| Bit | Meaning |
|---|---|
| 0 | saturate enable |
| 1 | signed (integer modes) or 16-bit narrowing (fractional mode) |
| 2 | round enable |
| 3 | fractional mode |
| 4 | sticky overflow flag |
| 11:8 | sticky per-accumulator overflow bits, bit 8+n for accumulator n |

All other status bits read as zero.

Top module: `mac_cond_unit`

## Requirements
- R1: After synchronous reset, all four accumulators and the status word are zero.
- R2: With `cmd_valid` low, nothing changes, whatever `cmd_op` and `wr_data` hold. A load command (code 1) writes all 64 bits of `wr_data` into accumulator `cmd_acc`.
- R3: Signed integer mode (bit 3 clear, bit 1 set) forms the signed 64-bit product. If the product lies outside the signed 40-bit range, the overflow flag is set. With saturate enabled, the product is then replaced by +2^50, or by the bitwise complement of 2^50 when the product is negative. With saturate disabled, the product is replaced by its low 40 bits sign-extended.
- R4: Unsigned integer mode (bits 3 and 1 clear) forms the unsigned product. Any set bit at position 40 or above sets the overflow flag. The product is then replaced by 2^50 with saturate enabled, or masked to its low 40 bits with saturate disabled.
- R5: Fractional mode (bit 3 set) arithmetically shifts the signed product right by 24. With round enabled, it adds one when the dropped 24 bits exceed 0x800000, or equal 0x800000 while the kept value is odd.
- R6: A multiply-accumulate adds the conditioned product to the accumulator and then applies the accumulator check of the active mode. Code 3 applies the same check to the accumulator unchanged. A check that finds overflow sets the overflow flag and the accumulator's own overflow bit.
- R7: Signed integer check: overflow means the value lies outside the signed 48-bit range. On overflow with saturate enabled, the result is 0x7FFFFFFF, or 0xFFFFFFFF80000000 when the 64-bit value is negative. With saturate disabled, the result is the low 48 bits sign-extended.
- R8: Unsigned check: overflow means any of bits 63:48 is set. With saturate enabled, the result is 0 when the value exceeds 2^53, and 2^48-1 otherwise. With saturate disabled, the value is masked to 48 bits.
- R9: Fractional check: overflow is detected as in R7. With saturate enabled, the result is 0x00007FFFFFFFFFFF, or 0xFFFF800000000000 for a negative value. With saturate disabled, it is the low 48 bits sign-extended.
- R10: Fractional readout has three cases. With bit 1 set, it keeps bits above 24 with round-half-to-even on the 24 dropped bits and gives a 16-bit result, zero-extended. Otherwise, with round enabled, it drops 8 bits with round-half-to-even at 0x80. Otherwise it plainly drops 8 bits. With saturate enabled, a value that does not fit the signed result width becomes 0x7FFF/0x8000 or 0x7FFFFFFF/0x80000000. With saturate disabled, the value is truncated.
- R11: Signed integer readout returns the low 32 bits when the accumulator fits in signed 32 bits, and otherwise 0x7FFFFFFF or 0x80000000 by sign. Unsigned readout returns 0xFFFFFFFF when bits 63:32 are nonzero, and otherwise the low 32 bits.
- R12: A copy command moves the source accumulator's value and its overflow bit to the destination.
- R13: The overflow flag and the per-accumulator overflow bits are sticky. Only a status write (code 5) or a copy onto that accumulator clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Single-cycle command strobe |
| cmd_op | input | 3 | Command code |
| cmd_acc | input | 2 | Destination accumulator |
| cmd_src | input | 2 | Source accumulator for the copy command |
| op_a | input | 32 | Multiplier operand A |
| op_b | input | 32 | Multiplier operand B |
| wr_data | input | 64 | Load value or status write value |
| rd_sel | input | 2 | Accumulator selected for readout |
| rd_acc | output | 64 | Raw contents of the selected accumulator |
| rd_word | output | 32 | Rounded and saturated readout of the selected accumulator |
| status | output | 16 | Status word |

## Verification
Products are driven with small mixed-sign operands, with full-scale operands that overflow 40 bits, and with fractional operands whose dropped bits fall just below, exactly on, and above the half point. The half-point cases use both even and odd kept values. Together these separate correct handling from truncation and from round-half-up. Each overflow case is repeated with saturate on and off, which shows whether the sentinel, the clamp or the truncation was applied. Readout is swept over all four accumulators under every mode combination, using values placed on either side of the 16- and 32-bit limits. After every command, a behavioural model in the bench is compared with the raw accumulators, the readout words and the status word.

// File: rtl/mac_cond_pkg.sv
package mac_cond_pkg;

    localparam int OPD_W     = 32;
    localparam int FULL_W    = 2 * OPD_W;
    localparam int ACC_W     = 48;
    localparam int PROD_FIT  = 40;
    localparam int SENT_BIT  = 50;
    localparam int UCLAMP_B  = 53;
    localparam int FRAC_SH   = 24;
    localparam int RD_SH     = 8;
    localparam int NARROW_W  = 16;
    localparam int WORD_W    = 32;
    localparam int N_ACC     = 4;
    localparam int SEL_W     = $clog2(N_ACC);
    localparam int SR_W      = 16;

    localparam logic [SR_W-1:0] SR_WMASK = 16'h0F1F;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_LOAD = 3'd1,
        OP_MAC  = 3'd2,
        OP_SAT  = 3'd3,
        OP_MOVE = 3'd4,
        OP_WRSR = 3'd5
    } mac_op_e;

    typedef enum logic [1:0] {
        MODE_UINT = 2'd0,
        MODE_SINT = 2'd1,
        MODE_FRAC = 2'd2
    } mac_mode_e;

    typedef struct packed {
        logic [3:0]       rsv_hi;
        logic [N_ACC-1:0] pav;
        logic [2:0]       rsv_mid;
        logic             ovf;
        logic             frac;
        logic             rnd;
        logic             sgn;
        logic             sat;
    } mac_sr_t;

    function automatic mac_mode_e mode_of(input mac_sr_t sr);
        if (sr.frac)
            return MODE_FRAC;
        else if (sr.sgn)
            return MODE_SINT;
        return MODE_UINT;
    endfunction

    function automatic logic fits_signed(input logic [FULL_W-1:0] v, input int bits);
        logic [FULL_W-1:0] s;
        s = $signed(v) >>> (bits - 1);
        return (s == '0) || (s == '1);
    endfunction

    function automatic logic [FULL_W-1:0] sext_low(input logic [FULL_W-1:0] v, input int bits);
        return $signed(v << (FULL_W - bits)) >>> (FULL_W - bits);
    endfunction

endpackage

// File: rtl/mac_prod_cond.sv
module mac_prod_cond
    import mac_cond_pkg::*;
#(
    parameter int DW  = OPD_W,
    parameter int FIT = PROD_FIT,
    parameter int SB  = SENT_BIT,
    parameter int SH  = FRAC_SH
) (
    input  logic [DW-1:0]   op_a,
    input  logic [DW-1:0]   op_b,
    input  mac_mode_e       mode,
    input  logic            sat,
    input  logic            rnd,
    output logic [2*DW-1:0] prod,
    output logic            ovf
);
    localparam int PW = 2 * DW;
    localparam logic [PW-1:0] SENT = {{(PW-1){1'b0}}, 1'b1} << SB;
    localparam logic [SH-1:0] HALF = {1'b1, {(SH-1){1'b0}}};

    logic [PW-1:0] sprod;
    logic [PW-1:0] uprod;
    logic [PW-1:0] kept;
    logic [SH-1:0] rem;
    logic          bump;

    always_comb begin
        sprod = $signed({{DW{op_a[DW-1]}}, op_a}) * $signed({{DW{op_b[DW-1]}}, op_b});
        uprod = {{DW{1'b0}}, op_a} * {{DW{1'b0}}, op_b};
        kept  = $signed(sprod) >>> SH;
        rem   = sprod[SH-1:0];
        bump  = rnd && ((rem > HALF) || ((rem == HALF) && kept[0]));
        ovf   = 1'b0;
        prod  = '0;
        case (mode)
            MODE_SINT: begin
                ovf = !fits_signed(sprod, FIT);
                if (ovf && sat)
                    prod = sprod[PW-1] ? ~SENT : SENT;
                else if (ovf)
                    prod = sext_low(sprod, FIT);
                else
                    prod = sprod;
            end
            MODE_UINT: begin
                ovf = |uprod[PW-1:FIT];
                if (ovf && sat)
                    prod = SENT;
                else
                    prod = {{(PW-FIT){1'b0}}, uprod[FIT-1:0]};
            end
            default: begin
                prod = kept + {{(PW-1){1'b0}}, bump};
            end
        endcase
    end

endmodule

// File: rtl/mac_acc_check.sv
module mac_acc_check
    import mac_cond_pkg::*;
#(
    parameter int W  = FULL_W,
    parameter int AW = ACC_W,
    parameter int WW = WORD_W,
    parameter int UB = UCLAMP_B
) (
    input  logic [W-1:0] val,
    input  mac_mode_e    mode,
    input  logic         sat,
    output logic [W-1:0] res,
    output logic         ovf
);
    localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] SMAX32  = (ONE << (WW - 1)) - ONE;
    localparam logic [W-1:0] SMAXACC = (ONE << (AW - 1)) - ONE;
    localparam logic [W-1:0] UMAXACC = (ONE << AW) - ONE;
    localparam logic [W-1:0] UBIG    = ONE << UB;

    logic neg;

    always_comb begin
        neg = val[W-1];
        ovf = 1'b0;
        res = val;
        case (mode)
            MODE_SINT: begin
                ovf = !fits_signed(val, AW);
                if (ovf)
                    res = sat ? (neg ? ~SMAX32 : SMAX32) : sext_low(val, AW);
            end
            MODE_FRAC: begin
                ovf = !fits_signed(val, AW);
                if (ovf)
                    res = sat ? (neg ? ~SMAXACC : SMAXACC) : sext_low(val, AW);
            end
            default: begin
                ovf = |val[W-1:AW];
                if (ovf && sat)
                    res = (val > UBIG) ? '0 : UMAXACC;
                else if (ovf)
                    res = val & UMAXACC;
            end
        endcase
    end

endmodule

// File: rtl/mac_readout.sv
module mac_readout
    import mac_cond_pkg::*;
#(
    parameter int W   = FULL_W,
    parameter int WW  = WORD_W,
    parameter int NW  = NARROW_W,
    parameter int SH1 = FRAC_SH,
    parameter int SH2 = RD_SH
) (
    input  logic [W-1:0]  acc,
    input  mac_mode_e     mode,
    input  logic          sat,
    input  logic          sgn,
    input  logic          rnd,
    output logic [WW-1:0] word
);
    localparam logic [SH1-1:0] HALF1 = {1'b1, {(SH1-1){1'b0}}};
    localparam logic [SH2-1:0] HALF2 = {1'b1, {(SH2-1){1'b0}}};
    localparam logic [WW-1:0]  SMAXW = {1'b0, {(WW-1){1'b1}}};
    localparam logic [NW-1:0]  SMAXN = {1'b0, {(NW-1){1'b1}}};

    logic [W-1:0]   kept;
    logic [SH1-1:0] rem1;
    logic [SH2-1:0] rem2;
    logic           bump;
    logic           neg;

    always_comb begin
        rem1 = acc[SH1-1:0];
        rem2 = acc[SH2-1:0];
        bump = 1'b0;
        if (sgn) begin
            kept = $signed(acc) >>> SH1;
            bump = (rem1 > HALF1) || ((rem1 == HALF1) && kept[0]);
        end else begin
            kept = $signed(acc) >>> SH2;
            bump = rnd && ((rem2 > HALF2) || ((rem2 == HALF2) && kept[0]));
        end
        kept = kept + {{(W-1){1'b0}}, bump};
        neg  = kept[W-1];
        word = '0;
        case (mode)
            MODE_FRAC: begin
                if (sgn) begin
                    if (sat && !fits_signed(kept, NW))
                        word = {{(WW-NW){1'b0}}, (neg ? ~SMAXN : SMAXN)};
                    else
                        word = {{(WW-NW){1'b0}}, kept[NW-1:0]};
                end else begin
                    if (sat && !fits_signed(kept, WW))
                        word = neg ? ~SMAXW : SMAXW;
                    else
                        word = kept[WW-1:0];
                end
            end
            MODE_SINT: begin
                if (fits_signed(acc, WW))
                    word = acc[WW-1:0];
                else
                    word = acc[W-1] ? ~SMAXW : SMAXW;
            end
            default: begin
                word = (|acc[W-1:WW]) ? '1 : acc[WW-1:0];
            end
        endcase
    end

endmodule

// File: rtl/mac_cond_unit.sv
module mac_cond_unit
    import mac_cond_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [SEL_W-1:0]  cmd_acc,
    input  logic [SEL_W-1:0]  cmd_src,
    input  logic [OPD_W-1:0]  op_a,
    input  logic [OPD_W-1:0]  op_b,
    input  logic [FULL_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [FULL_W-1:0] rd_acc,
    output logic [WORD_W-1:0] rd_word,
    output logic [SR_W-1:0]   status
);
    logic [FULL_W-1:0] acc_q [N_ACC];
    mac_sr_t           sr_q;
    mac_sr_t           sr_d;
    mac_op_e           op;
    mac_mode_e         mode;
    logic [FULL_W-1:0] prod;
    logic [FULL_W-1:0] chk_in;
    logic [FULL_W-1:0] chk_res;
    logic              prod_ovf;
    logic              chk_ovf;

    assign op   = mac_op_e'(cmd_op);
    assign mode = mode_of(sr_q);

    mac_prod_cond u_prod (
        .op_a (op_a),
        .op_b (op_b),
        .mode (mode),
        .sat  (sr_q.sat),
        .rnd  (sr_q.rnd),
        .prod (prod),
        .ovf  (prod_ovf)
    );

    assign chk_in = (op == OP_MAC) ? (acc_q[cmd_acc] + prod) : acc_q[cmd_acc];

    mac_acc_check u_check (
        .val  (chk_in),
        .mode (mode),
        .sat  (sr_q.sat),
        .res  (chk_res),
        .ovf  (chk_ovf)
    );

    for (genvar g = 0; g < N_ACC; g++) begin : g_acc
        logic [FULL_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (cmd_valid && (cmd_acc == SEL_W'(g))) begin
                case (op)
                    OP_LOAD:         q <= wr_data;
                    OP_MAC, OP_SAT:  q <= chk_res;
                    OP_MOVE:         q <= acc_q[cmd_src];
                    default:         q <= q;
                endcase
            end
        end
        assign acc_q[g] = q;
    end

    always_comb begin
        sr_d = sr_q;
        if (cmd_valid) begin
            case (op)
                OP_MAC: begin
                    sr_d.ovf          = sr_q.ovf | prod_ovf | chk_ovf;
                    sr_d.pav[cmd_acc] = sr_q.pav[cmd_acc] | chk_ovf;
                end
                OP_SAT: begin
                    sr_d.ovf          = sr_q.ovf | chk_ovf;
                    sr_d.pav[cmd_acc] = sr_q.pav[cmd_acc] | chk_ovf;
                end
                OP_MOVE: begin
                    sr_d.pav[cmd_acc] = sr_q.pav[cmd_src];
                end
                OP_WRSR: begin
                    sr_d = mac_sr_t'(wr_data[SR_W-1:0] & SR_WMASK);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            sr_q <= '0;
        else
            sr_q <= sr_d;
    end

    mac_readout u_read (
        .acc  (acc_q[rd_sel]),
        .mode (mode),
        .sat  (sr_q.sat),
        .sgn  (sr_q.sgn),
        .rnd  (sr_q.rnd),
        .word (rd_word)
    );

    assign rd_acc = acc_q[rd_sel];
    assign status = sr_q;

endmodule

// File: rtl/mac_cond_unit_chk.sv
module mac_cond_unit_chk
    import mac_cond_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic [SEL_W-1:0]  cmd_acc,
    input logic [SEL_W-1:0]  cmd_src,
    input logic [FULL_W-1:0] rd_acc,
    input logic [WORD_W-1:0] rd_word,
    input logic [SR_W-1:0]   status
);
    logic             is_wrsr;
    logic             is_move;
    logic             src_pav;
    logic             acc_fits32;
    logic [N_ACC-1:0] pav;

    assign is_wrsr    = cmd_valid && (cmd_op == 3'd5);
    assign is_move    = cmd_valid && (cmd_op == 3'd4);
    assign pav        = status[8 +: N_ACC];
    assign src_pav    = pav[cmd_src];
    assign acc_fits32 = (&rd_acc[FULL_W-1:WORD_W-1]) || !(|rd_acc[FULL_W-1:WORD_W-1]);

    a_r13_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (status[4] && !is_wrsr) |=> status[4]);

    a_r13_pav_sticky: assert property (@(posedge clk) disable iff (rst)
        (!is_wrsr && !is_move) |=> ((pav & $past(pav)) == $past(pav)));

    a_r12_move_pav: assert property (@(posedge clk) disable iff (rst)
        is_move |=> (pav[$past(cmd_acc)] == $past(src_pav)));

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> $stable(status));

    a_r11_uint_clip: assert property (@(posedge clk) disable iff (rst)
        (!status[3] && !status[1] && (|rd_acc[FULL_W-1:WORD_W])) |-> (rd_word == '1));

    a_r11_sint_pass: assert property (@(posedge clk) disable iff (rst)
        (!status[3] && status[1] && acc_fits32) |-> (rd_word == rd_acc[WORD_W-1:0]));

endmodule

bind mac_cond_unit mac_cond_unit_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_acc   (cmd_acc),
    .cmd_src   (cmd_src),
    .rd_acc    (rd_acc),
    .rd_word   (rd_word),
    .status    (status)
);

// File: tb/mac_cond_unit_tb_top.sv
`timescale 1ns/1ps
module mac_cond_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [1:0]  cmd_acc;
    logic [1:0]  cmd_src;
    logic [31:0] op_a;
    logic [31:0] op_b;
    logic [63:0] wr_data;
    logic [1:0]  rd_sel;
    logic [63:0] rd_acc;
    logic [31:0] rd_word;
    logic [15:0] status;

    int errors = 0;
    int checks = 0;

    logic [63:0] macc [4];
    logic [15:0] msr;

    always #2 clk = ~clk;

    mac_cond_unit dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_acc(cmd_acc), .cmd_src(cmd_src), .op_a(op_a), .op_b(op_b),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_acc(rd_acc),
        .rd_word(rd_word), .status(status)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic logic [63:0] ref_prod(input logic [31:0] a, input logic [31:0] b,
                                             input logic [15:0] sr, output logic ov);
        longint sp, lim, k;
        logic [63:0] up;
        logic [23:0] r;
        ov  = 1'b0;
        sp  = longint'($signed(a)) * longint'($signed(b));
        up  = 64'(a) * 64'(b);
        lim = longint'(1) <<< 39;
        if (sr[3]) begin
            k = sp >>> 24;
            r = sp[23:0];
            if (sr[2] && (r > 24'h800000 || (r == 24'h800000 && k[0]))) k = k + 1;
            return k;
        end else if (sr[1]) begin
            if (sp < -lim || sp >= lim) begin
                ov = 1'b1;
                if (sr[0]) return (sp < 0) ? ~(64'd1 << 50) : (64'd1 << 50);
                return (sp <<< 24) >>> 24;
            end
            return sp;
        end
        if (up >= (64'd1 << 40)) begin
            ov = 1'b1;
            if (sr[0]) return 64'd1 << 50;
            return up % (64'd1 << 40);
        end
        return up;
    endfunction

    function automatic logic [63:0] ref_check(input logic [63:0] v, input logic [15:0] sr,
                                              output logic ov);
        longint s, lim;
        s   = v;
        lim = longint'(1) <<< 47;
        if (sr[3] || sr[1]) begin
            ov = (s < -lim) || (s >= lim);
            if (!ov) return v;
            if (sr[0] && sr[3]) return (s < 0) ? -lim : lim - 1;
            if (sr[0]) return (s < 0) ? -(longint'(1) <<< 31) : (longint'(1) <<< 31) - 1;
            return (s <<< 16) >>> 16;
        end
        ov = (v >= (64'd1 << 48));
        if (!ov) return v;
        if (sr[0]) return (v > (64'd1 << 53)) ? 64'd0 : (64'd1 << 48) - 1;
        return v % (64'd1 << 48);
    endfunction

    function automatic logic [31:0] ref_read(input logic [63:0] v, input logic [15:0] sr);
        longint s, k;
        s = v;
        if (sr[3]) begin
            if (sr[1]) begin
                k = s >>> 24;
                if (v[23:0] > 24'h800000 || (v[23:0] == 24'h800000 && k[0])) k = k + 1;
                if (sr[0] && (k < -32768 || k > 32767)) return (k < 0) ? 32'h8000 : 32'h7FFF;
                return {16'h0, k[15:0]};
            end
            k = s >>> 8;
            if (sr[2] && (v[7:0] > 8'h80 || (v[7:0] == 8'h80 && k[0]))) k = k + 1;
            if (sr[0] && (k < -(longint'(1) <<< 31) || k >= (longint'(1) <<< 31)))
                return (k < 0) ? 32'h80000000 : 32'h7FFFFFFF;
            return k[31:0];
        end
        if (sr[1]) begin
            if (s >= -(longint'(1) <<< 31) && s < (longint'(1) <<< 31)) return v[31:0];
            return (s < 0) ? 32'h80000000 : 32'h7FFFFFFF;
        end
        return (v[63:32] != 0) ? 32'hFFFFFFFF : v[31:0];
    endfunction

    task automatic sweep(input string tag);
        for (int i = 0; i < 4; i++) begin
            rd_sel = 2'(i);
            #0.1;
            check({tag, " acc"}, rd_acc, macc[i]);
            check({tag, " word"}, 64'(rd_word), 64'(ref_read(macc[i], msr)));
        end
        check({tag, " status"}, 64'(status), 64'(msr));
    endtask

    task automatic model_step(input logic [2:0] op, input logic [1:0] d, input logic [1:0] s,
                              input logic [31:0] a, input logic [31:0] b, input logic [63:0] w);
        logic pov, cov;
        logic [63:0] p, r;
        case (op)
            3'd1: macc[d] = w;
            3'd2: begin
                p = ref_prod(a, b, msr, pov);
                r = ref_check(macc[d] + p, msr, cov);
                macc[d] = r;
                if (pov || cov) msr[4] = 1'b1;
                if (cov) msr[8 + d] = 1'b1;
            end
            3'd3: begin
                r = ref_check(macc[d], msr, cov);
                macc[d] = r;
                if (cov) begin msr[4] = 1'b1; msr[8 + d] = 1'b1; end
            end
            3'd4: begin
                macc[d] = macc[s];
                msr[8 + d] = msr[8 + s];
            end
            3'd5: msr = w[15:0] & 16'h0F1F;
            default: ;
        endcase
    endtask

    task automatic cmd(input string tag, input logic [2:0] op, input logic [1:0] d,
                       input logic [1:0] s, input logic [31:0] a, input logic [31:0] b,
                       input logic [63:0] w);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_acc = d; cmd_src = s;
        op_a = a; op_b = b; wr_data = w;
        @(posedge clk);
        model_step(op, d, s, a, b, w);
        @(negedge clk);
        cmd_valid = 1'b0;
        sweep(tag);
    endtask

    task automatic wrsr(input string tag, input logic [15:0] v);
        cmd(tag, 3'd5, 2'd0, 2'd0, 32'd0, 32'd0, {48'd0, v});
    endtask

    task automatic load(input string tag, input logic [1:0] d, input logic [63:0] v);
        cmd(tag, 3'd1, d, 2'd0, 32'd0, 32'd0, v);
    endtask

    task automatic mac(input string tag, input logic [1:0] d, input logic [31:0] a, input logic [31:0] b);
        cmd(tag, 3'd2, d, 2'd0, a, b, 64'd0);
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_acc = '0; cmd_src = '0;
        op_a = '0; op_b = '0; wr_data = '0; rd_sel = '0;
        for (int i = 0; i < 4; i++) macc[i] = '0;
        msr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        sweep("R1");

        load("R2", 2'd1, 64'h0000_1234_5678_9ABC);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd1; cmd_acc = 2'd1; wr_data = 64'hDEAD_BEEF_0000_0001;
        @(posedge clk);
        @(negedge clk);
        sweep("R2 idle");

        wrsr("R3 mode", 16'h0002);
        mac("R3 small", 2'd0, 32'd1000, -32'sd3);
        mac("R3 trunc", 2'd0, 32'h7FFFFFFF, 32'h7FFFFFFF);
        wrsr("R13 clear", 16'h0003);
        mac("R3 sentinel R7", 2'd2, 32'h7FFFFFFF, 32'h7FFFFFFF);
        mac("R3 neg sentinel R7", 2'd3, 32'h80000000, 32'h7FFFFFFF);
        load("R7 load", 2'd1, 64'h0000_9000_0000_0000);
        cmd("R7 nosat", 3'd3, 2'd1, 2'd0, 0, 0, 0);
        wrsr("R7 mode", 16'h0002);
        load("R7 load2", 2'd1, 64'hFFFF_0000_0000_0005);
        cmd("R7 trunc", 3'd3, 2'd1, 2'd0, 0, 0, 0);

        wrsr("R4 mode", 16'h0000);
        mac("R4 mask", 2'd0, 32'hFFFFFFFF, 32'hFFFFFFFF);
        mac("R4 fit", 2'd0, 32'd70000, 32'd90000);
        wrsr("R4 sat", 16'h0001);
        mac("R4 sentinel R8", 2'd1, 32'hFFFFFFFF, 32'hFFFFFFFF);
        load("R8 big", 2'd2, 64'hFFFF_FFFF_FFFF_0000);
        cmd("R8 clamp0", 3'd3, 2'd2, 2'd0, 0, 0, 0);
        wrsr("R8 nosat", 16'h0000);
        load("R8 big2", 2'd2, 64'h0003_0000_0000_0042);
        cmd("R8 mask", 3'd3, 2'd2, 2'd0, 0, 0, 0);

        wrsr("R5 mode rnd", 16'h000C);
        for (int i = 0; i < 4; i++) load("R5 clr", 2'(i), 64'd0);
        mac("R5 tie even", 2'd0, 32'h00800000, 32'd1);
        mac("R5 tie odd", 2'd1, 32'h00800000, 32'd3);
        mac("R5 above", 2'd2, 32'h00800001, 32'd1);
        mac("R5 neg", 2'd3, 32'hFF7FFFFF, 32'd5);
        wrsr("R5 trunc", 16'h0008);
        mac("R5 nornd", 2'd1, 32'h00800000, 32'd3);
        wrsr("R9 sat", 16'h0009);
        load("R9 near", 2'd0, 64'h0000_7FFF_FFFF_FFFF);
        mac("R9 sat pos R6", 2'd0, 32'h7FFFFFFF, 32'h7FFFFFFF);
        load("R9 nearneg", 2'd1, 64'hFFFF_8000_0000_0000);
        mac("R9 sat neg", 2'd1, 32'h80000000, 32'h7FFFFFFF);
        wrsr("R9 nosat", 16'h0008);
        load("R9 over", 2'd2, 64'h0001_7000_0000_0000);
        cmd("R9 trunc", 3'd3, 2'd2, 2'd0, 0, 0, 0);

        load("R10 a", 2'd0, 64'h0000_0012_3480_0000);
        load("R10 b", 2'd1, 64'h0000_0012_3580_0080);
        load("R10 c", 2'd2, 64'h0000_7FFF_FFFF_FF80);
        load("R10 d", 2'd3, 64'hFFFF_8000_0000_0180);
        wrsr("R10 plain", 16'h0008);
        wrsr("R10 rnd", 16'h000C);
        wrsr("R10 rnd sat", 16'h000D);
        wrsr("R10 narrow", 16'h000A);
        wrsr("R10 narrow sat", 16'h000B);

        load("R11 a", 2'd0, 64'h0000_0000_7FFF_FFFF);
        load("R11 b", 2'd1, 64'hFFFF_FFFF_8000_0000);
        load("R11 c", 2'd2, 64'h0000_0001_0000_0000);
        load("R11 d", 2'd3, 64'hFFFF_FFFF_7FFF_FFFF);
        wrsr("R11 signed", 16'h0002);
        wrsr("R11 unsigned", 16'h0000);

        wrsr("R12 setpav", 16'h0203);
        cmd("R12 move", 3'd4, 2'd3, 2'd1, 0, 0, 0);
        cmd("R12 move clr", 3'd4, 2'd1, 2'd0, 0, 0, 0);
        cmd("R13 sat keep", 3'd3, 2'd3, 2'd0, 0, 0, 0);
        wrsr("R13 wipe", 16'hFFF0);
        wrsr("R13 zero", 16'h0000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule